// File: doc/BRIEF.md
# Bit-Serial Multiply-Shift-Add Processing Element

This block is one processing element for an array of identical units that pass 16-bit fixed-point words to each other over single-wire serial links, one bit per clock. Each iteration lasts 96 cycles and is split into three 32-cycle slots. In every slot the element receives two serial operands and uses a coefficient that is presented in parallel. It produces one serial result: the coefficient times the first operand, truncated to 16 bits, plus the second operand shifted right arithmetically by an amount fixed for that slot.

A local hard-wired sequencer steps through the slots and drives every select and strobe in the datapath. The datapath has four parts:
- a serial-parallel fractional multiplier, which sign-extends its serial input for the upper half of each slot;
- a delay-line shifter, which right-shifts by tapping the input history late and then repeating the sign bit;
- a single-bit adder with a carry flop, cleared at the start of each word;
- an output register.

Operands may arrive fresh in every slot, so a neighbour can send the same word again instead of the element storing it.

Top module: `bitser_pe`

## Requirements
- R1: While `rstN` is low, `serOut` and `outValid` are 0 and `iterStart` is 1.
- R2: `iterStart` is high in exactly one cycle of every 96. The first such cycle is the one that immediately follows the release of reset.
- R3: Both serial operands enter LSB first in slot cycles 0 to 15, where cycle 0 of slot 0 is the `iterStart` cycle. Values on `serInA` and `serInB` in slot cycles 16 to 31 have no effect on the result.
- R4: `coefWord` is a signed Q1.15 value sampled only in slot cycle 0 and held for the rest of that slot. Its value in other cycles has no effect.
- R5: The product term is bits 30 down to 15 of the 32-bit signed product of operand A and the coefficient. Overflow wraps, so 0x8000 times 0x8000 gives 0x8000.
- R6: The shift term is operand B shifted right arithmetically by the slot's amount, 0 to 15. The amount for slot k is bits [4k+3:4k] of parameter `SHIFT_SCHED`.
- R7: The result of a slot leaves on `serOut` LSB first in slot cycles 16 to 31. `outValid` is high in exactly those cycles, and `serOut` is 0 whenever `outValid` is low.
- R8: The result is the sum of the two terms modulo 2^16. No carry passes from one word into the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| serInA | input | 1 | Serial multiplicand operand, LSB first |
| serInB | input | 1 | Serial operand for the shifter, LSB first |
| coefWord | input | WORD_W | Parallel Q1.15 coefficient, sampled in slot cycle 0 |
| serOut | output | 1 | Serial result, LSB first |
| outValid | output | 1 | High while a result bit is on serOut |
| iterStart | output | 1 | High in cycle 0 of slot 0 of each iteration |

## Verification
The bench builds the element with the default 16-bit word and three slots, and sets `SHIFT_SCHED` to 12'hF06. The three slots therefore use shifts of 6, 0 and 15, which covers both extremes of the shifter and one middle tap in every iteration. Operands and coefficients first run through every combination of 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF, which reaches the -1 times -1 wrap and the sum overflow. Random words follow. Random bits are driven on all inputs in the cycles where they must be ignored.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

  // Per-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic wordStart;  // slot cycle 0
    logic msbCycle;   // last operand bit arrives, first add cycle
    logic inPhase;    // operand bits are on the serial inputs
    logic addPhase;   // adder produces a result bit
  } peStrobes_t;

endpackage

// File: rtl/bitser_seq.sv
module bitser_seq
  import bitser_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_SLOTS = 3,
  parameter logic [NUM_SLOTS*$clog2(WORD_W)-1:0] SHIFT_SCHED = 12'hF06
) (
  input  logic                          clk,
  input  logic                          rstN,
  output peStrobes_t                    strb,
  output logic [$clog2(WORD_W)-1:0]     shiftAmt,
  output logic [$clog2(2*WORD_W)-1:0]   phase,
  output logic                          iterStart
);
  localparam int SLOT_LEN  = 2 * WORD_W;
  localparam int PH_W      = $clog2(SLOT_LEN);
  localparam int SH_W      = $clog2(WORD_W);
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0]   MSB_PH    = PH_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [PH_W-1:0]   phReg;
  logic [SLOT_W-1:0] slotReg;
  logic [SH_W-1:0]   shiftTab [NUM_SLOTS];

  // Unpack the per-slot shift schedule.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sched
    assign shiftTab[g] = SHIFT_SCHED[g*SH_W +: SH_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phReg   <= '0;
      slotReg <= '0;
    end else if (phReg == LAST_PH) begin
      phReg   <= '0;
      slotReg <= (slotReg == LAST_SLOT) ? '0 : slotReg + 1'b1;
    end else begin
      phReg <= phReg + 1'b1;
    end
  end

  always_comb begin
    strb.wordStart = (phReg == '0);
    strb.msbCycle  = (phReg == MSB_PH);
    strb.inPhase   = (phReg <= MSB_PH);
    strb.addPhase  = (phReg >= MSB_PH) && (phReg != LAST_PH);
  end

  assign shiftAmt  = shiftTab[slotReg];
  assign phase     = phReg;
  assign iterStart = (phReg == '0) && (slotReg == '0);

  // R2: an iteration start is never followed directly by another
  p_iter_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    iterStart |=> !iterStart);

  // R3: the end of a slot is followed by the start of a new word
  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phReg == LAST_PH) |=> strb.wordStart);

endmodule

// File: rtl/bitser_mul.sv
module bitser_mul #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAcc,
  input  logic              mulIn,
  input  logic [WORD_W-1:0] coef,
  output logic              prodBit
);
  localparam int ACC_W = WORD_W + 2;

  logic signed [ACC_W-1:0] accReg;
  logic signed [ACC_W-1:0] accUse;
  logic signed [ACC_W-1:0] coefExt;
  logic signed [ACC_W-1:0] sum;

  // Serial-parallel step: add the coefficient for a 1 bit, emit the LSB, halve.
  assign coefExt = {{2{coef[WORD_W-1]}}, coef};
  assign accUse  = clearAcc ? '0 : accReg;
  assign sum     = accUse + (mulIn ? coefExt : '0);
  assign prodBit = sum[0];

  always_ff @(posedge clk) begin
    if (!rstN) accReg <= '0;
    else       accReg <= sum >>> 1;
  end

endmodule

// File: rtl/bitser_datapath.sv
module bitser_datapath
  import bitser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  peStrobes_t                    strb,
  input  logic [$clog2(WORD_W)-1:0]     shiftAmt,
  input  logic [$clog2(2*WORD_W)-1:0]   phase,
  input  logic                          serInA,
  input  logic                          serInB,
  input  logic [WORD_W-1:0]             coefWord,
  output logic                          serOut,
  output logic                          outValid
);
  localparam int SH_W = $clog2(WORD_W);
  localparam int PH_W = $clog2(2*WORD_W);
  localparam logic [PH_W:0]   TAIL_LIM = (PH_W+1)'(2*WORD_W - 2);
  localparam logic [SH_W-1:0] MAX_TAP  = SH_W'(WORD_W - 1);

  logic [WORD_W-1:0] coefReg;
  logic [WORD_W-1:0] coefUse;
  logic              aSign;
  logic              bSign;
  logic [WORD_W-1:0] bHist;
  logic              mulIn;
  logic              prodBit;
  logic [PH_W:0]     reach;
  logic              inTail;
  logic [SH_W-1:0]   tapDelay;
  logic              shBit;
  logic              carryReg;
  logic              carryUse;
  logic              sumBit;
  logic              carryNext;
  logic              serOutReg;
  logic              outValidReg;

  // Coefficient register: parallel word latched at slot start.
  assign coefUse = strb.wordStart ? coefWord : coefReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefReg <= '0;
      aSign   <= 1'b0;
      bSign   <= 1'b0;
      bHist   <= '0;
    end else begin
      if (strb.wordStart) coefReg <= coefWord;
      if (strb.msbCycle) begin
        aSign <= serInA;
        bSign <= serInB;
      end
      bHist <= {bHist[WORD_W-2:0], serInB};
    end
  end

  // Multiplier input: live bits, then sign extension for the upper half.
  assign mulIn = strb.inPhase ? serInA : aSign;

  bitser_mul #(.WORD_W(WORD_W)) u_mul (
    .clk      (clk),
    .rstN     (rstN),
    .clearAcc (strb.wordStart),
    .mulIn    (mulIn),
    .coef     (coefUse),
    .prodBit  (prodBit)
  );

  // Shifter: result bit j needs operand bit j+s, which arrived WORD_W-1-s cycles ago.
  assign reach    = {1'b0, phase} + {{(PH_W+1-SH_W){1'b0}}, shiftAmt};
  assign inTail   = reach > TAIL_LIM;
  assign tapDelay = MAX_TAP - shiftAmt;

  always_comb begin
    if (inTail)               shBit = bSign;
    else if (tapDelay == '0)  shBit = serInB;
    else                      shBit = bHist[tapDelay - 1'b1];
  end

  // Serial adder, carry cleared on the first result bit.
  assign carryUse  = strb.msbCycle ? 1'b0 : carryReg;
  assign sumBit    = prodBit ^ shBit ^ carryUse;
  assign carryNext = (prodBit & shBit) | (prodBit & carryUse) | (shBit & carryUse);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryReg    <= 1'b0;
      serOutReg   <= 1'b0;
      outValidReg <= 1'b0;
    end else begin
      if (strb.addPhase) carryReg <= carryNext;
      serOutReg   <= strb.addPhase & sumBit;
      outValidReg <= strb.addPhase;
    end
  end

  assign serOut   = serOutReg;
  assign outValid = outValidReg;

  // R7: the output line is quiet outside the result window
  p_out_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !serOut);

  // R7: the result window opens one cycle after the operand MSB cycle
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(strb.msbCycle));

  // R3: the captured sign of operand A holds through the extension half
  p_sign_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inPhase |=> $stable(aSign));

  // R4: the coefficient register changes only at a slot start
  p_coef_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wordStart |=> $stable(coefReg));

endmodule

// File: rtl/bitser_pe.sv
module bitser_pe
  import bitser_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_SLOTS = 3,
  parameter logic [NUM_SLOTS*$clog2(WORD_W)-1:0] SHIFT_SCHED = 12'hF06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serInA,
  input  logic              serInB,
  input  logic [WORD_W-1:0] coefWord,
  output logic              serOut,
  output logic              outValid,
  output logic              iterStart
);
  localparam int SH_W = $clog2(WORD_W);
  localparam int PH_W = $clog2(2*WORD_W);

  peStrobes_t      strb;
  logic [SH_W-1:0] shiftAmt;
  logic [PH_W-1:0] phase;

  bitser_seq #(
    .WORD_W      (WORD_W),
    .NUM_SLOTS   (NUM_SLOTS),
    .SHIFT_SCHED (SHIFT_SCHED)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shiftAmt  (shiftAmt),
    .phase     (phase),
    .iterStart (iterStart)
  );

  bitser_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .shiftAmt (shiftAmt),
    .phase    (phase),
    .serInA   (serInA),
    .serInB   (serInB),
    .coefWord (coefWord),
    .serOut   (serOut),
    .outValid (outValid)
  );

endmodule

// File: tb/test_bitser_pe.sv
`timescale 1ns/1ps
module test_bitser_pe;
  localparam int WORD_W   = 16;
  localparam int SLOT_LEN = 32;
  localparam int PERIOD   = 96;
  localparam int ITERS    = 300;
  localparam logic [11:0] SCHED = 12'hF06;  // slot0=6, slot1=0, slot2=15

  logic clk = 1'b0;
  logic rstN;
  logic serInA, serInB;
  logic [WORD_W-1:0] coefWord;
  logic serOut, outValid, iterStart;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitser_pe #(.WORD_W(WORD_W), .NUM_SLOTS(3), .SHIFT_SCHED(SCHED)) i_bitser_pe (
    .clk(clk), .rstN(rstN), .serInA(serInA), .serInB(serInB),
    .coefWord(coefWord), .serOut(serOut), .outValid(outValid),
    .iterStart(iterStart)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      default: return 16'hFFFF;
    endcase
  endfunction

  // R5 R6 R8: truncated Q1.15 product plus arithmetic shift, modulo 2^16
  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] c, input logic [3:0] s);
    logic signed [31:0] p;
    logic signed [15:0] sh;
    p  = $signed(a) * $signed(c);
    p  = p >>> 15;
    sh = $signed(b) >>> s;
    return p[15:0] + sh;
  endfunction

  initial begin
    logic [15:0] curA, curB, curC, expWord, gotWord;
    int opNum;
    opNum = 0;
    curA = '0; curB = '0; curC = '0; expWord = '0; gotWord = '0;
    rstN = 1'b0; serInA = 1'b0; serInB = 1'b0; coefWord = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(serOut == 1'b0, "R1 serOut in reset", 32'(serOut), 32'h0);
    chk(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 32'h0);
    chk(iterStart == 1'b1, "R1 iterStart in reset", 32'(iterStart), 32'h1);
    rstN = 1'b1;
    for (int cyc = 0; cyc < ITERS * PERIOD; cyc++) begin
      int ph, sl;
      ph = cyc % SLOT_LEN;
      sl = (cyc / SLOT_LEN) % 3;
      // R2: iteration marker once per 96 cycles
      chk(iterStart == (cyc % PERIOD == 0), "R2 iterStart", 32'(iterStart), 32'(cyc % PERIOD == 0));
      // R7: result window
      chk(outValid == (ph >= WORD_W), "R7 outValid", 32'(outValid), 32'(ph >= WORD_W));
      if (ph >= WORD_W) gotWord[ph - WORD_W] = serOut;
      else chk(serOut == 1'b0, "R7 serOut quiet", 32'(serOut), 32'h0);
      if (ph == SLOT_LEN - 1)
        // R3 R4 R5 R6 R7 R8: full serial word against the arithmetic model
        chk(gotWord == expWord, $sformatf("R5 R6 R8 word slot %0d (R3 R4 junk inputs)", sl),
            32'(gotWord), 32'(expWord));
      if (ph == 0) begin
        if (opNum < 125) begin
          curA = corner(opNum % 5);
          curC = corner((opNum / 5) % 5);
          curB = corner(opNum / 25);
        end else begin
          curA = 16'($urandom);
          curB = 16'($urandom);
          curC = 16'($urandom);
        end
        expWord = model(curA, curB, curC, SCHED[sl*4 +: 4]);
        opNum++;
      end
      serInA   = (ph < WORD_W) ? curA[ph] : 1'($urandom);
      serInB   = (ph < WORD_W) ? curB[ph] : 1'($urandom);
      coefWord = (ph == 0) ? curC : 16'($urandom);
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule